// File: doc/BRIEF.md
# SPI Register Access Bridge

This block is an SPI slave (mode 0, MSB first) that lets an external host read and write a small bank of 8-bit registers. The host frames each request with chip select. The first byte is a control byte that carries the direction and the start address. Data bytes follow. Inside a request a raw zero byte is reserved: from the host it ends the request, and from the slave it signals invalid data. Any data value of 0x00 or 0x5C therefore travels as a two-byte escape sequence in either direction.

The slave answers every byte one byte late, so the byte it shifts out while the control byte comes in is filler. The address counter advances after each register transfer, except at the buffer address 0x18, which a request can stream through repeatedly. An event input collects status changes in a flag register at address 0x01. While any flag is set, an active-low interrupt output is held low. Reading the flag register clears it.

All serial inputs are oversampled and synchronised in the system clock domain. SCLK must therefore stay at or below about one eighth of the system clock.

Top module: `spi_reg_bridge`

## Requirements
- R1: After reset every register reads as zero, irq_no is high and the idle reply byte is 0xFF.
- R2: SPI mode 0: MOSI is sampled on rising SCLK, MISO changes on falling SCLK, MSB first. Replies lag by one byte, and the reply during the control byte is 0xFF.
- R3: A control byte with bit 7 set starts a read at the address in bits 5:0. Each following non-zero host byte returns the next register in address order.
- R4: A control byte with bit 7 clear starts a write at the address in bits 5:0. Data bytes go into successive registers, and each byte is answered with 0xFF.
- R5: A raw 0x00 from the host ends the request. Later bytes before chip select rises are answered with 0xFF and change no register.
- R6: A register value of 0x00 or 0x5C is sent as 0x5C followed by the value XOR 0x20. Outside the invalid-data state the slave never sends a raw 0x00.
- R7: A received 0x5C followed by byte b stores b XOR 0x20 when that result is 0x00 or 0x5C. Any other follower is invalid data.
- R8: Invalid data is any of: a zero control byte, an address at or beyond NUM_REGS (including running past the end), or a bad escape. The slave then replies 0x00, ignores all traffic and writes nothing until chip select is released. The next request works normally.
- R9: Transfers at address 0x18 do not advance the address counter.
- R10: A non-zero evt_i ORs into the flag register at 0x01 and pulls irq_no low. A read of 0x01 returns the flags, clears them and releases irq_no. Host writes to 0x01 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI serial clock from host |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| evt_i | input | 8 | Status event pulses, one bit per cause |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The bench goes after the escape paths in both directions. A bridge that forwards 0x00 or 0x5C raw would end the host's view of the request early. One that decodes a wrong follower would silently store garbage instead of faulting. Invalid data is exercised through a zero control byte, an out-of-range start address, and reads and writes that run past the last register. After each fault the bench checks that no register changed and that the next request recovers; a sticky-fault bug shows up as a dead bus. Bytes sent after a terminator are checked for no effect. The buffer address is checked for a counter that does not advance, since a counter that advanced would leak writes into address 0x19. The flag register is checked for clear-on-read, and for host writes that must neither clear it nor release the interrupt.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int unsigned CTRL_AW = 6;
  localparam logic [7:0] ESC_CHAR  = 8'h5C;
  localparam logic [7:0] ESC_FLIP  = 8'h20;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [7:0] FAULT_BYTE = 8'h00;

  typedef enum logic [2:0] {
    ST_CTRL,
    ST_READ,
    ST_WRITE,
    ST_DONE,
    ST_FAULT
  } frame_st_e;

  function automatic logic needs_esc(input logic [7:0] v);
    return (v == 8'h00) || (v == ESC_CHAR);
  endfunction
endpackage

// File: rtl/spi_rb_shifter.sv
module spi_rb_shifter #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  input  logic [7:0] tx_byte_i,
  output logic       miso_o,
  output logic       cs_act_o,
  output logic [7:0] rx_byte_o,
  output logic       rx_valid_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclk_s, cs_s, mosi_s;
  logic       sclk_d;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;
  logic       rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_s <= {sclk_s[SYNC_STAGES-2:0], sclk_i};
      cs_s   <= {cs_s[SYNC_STAGES-2:0], cs_ni};
      mosi_s <= {mosi_s[SYNC_STAGES-2:0], mosi_i};
      sclk_d <= sclk_s[LAST];
    end
  end

  assign rise     = sclk_s[LAST] & ~sclk_d;
  assign fall     = ~sclk_s[LAST] & sclk_d;
  assign cs_act_o = ~cs_s[LAST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= spi_rb_pkg::FILL_BYTE;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (!cs_act_o) begin
        bit_cnt <= '0;
        tx_sh   <= tx_byte_i;
      end else if (rise) begin
        rx_sh   <= {rx_sh[5:0], mosi_s[LAST]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          rx_byte_o  <= {rx_sh, mosi_s[LAST]};
          rx_valid_o <= 1'b1;
        end
      end else if (fall) begin
        // byte boundary: load the reply chosen from the previous byte
        if (bit_cnt == 3'd0) tx_sh <= tx_byte_i;
        else                 tx_sh <= {tx_sh[6:0], 1'b0};
      end
    end
  end

  assign miso_o = tx_sh[7];
endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
  import spi_rb_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 32,
  parameter int unsigned BUF_ADDR  = 24,
  parameter int unsigned FLAG_ADDR = 1,
  parameter int unsigned IW        = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_act_i,
  input  logic               rx_valid_i,
  input  logic [7:0]         rx_byte_i,
  input  logic [7:0]         rd_data_i,
  output logic [7:0]         tx_byte_o,
  output logic [IW-1:0]      rd_idx_o,
  output logic [IW-1:0]      wr_idx_o,
  output logic               we_o,
  output logic [7:0]         wdata_o,
  output logic               flag_clr_o,
  output logic               err_o,
  output logic [CTRL_AW:0]   addr_o
);
  localparam logic [CTRL_AW:0] NUM_L  = (CTRL_AW + 1)'(NUM_REGS);
  localparam logic [CTRL_AW:0] BUF_L  = (CTRL_AW + 1)'(BUF_ADDR);
  localparam logic [CTRL_AW:0] FLAG_L = (CTRL_AW + 1)'(FLAG_ADDR);

  frame_st_e        st_q, st_d;
  logic [CTRL_AW:0] addr_q, addr_d, rd_ptr;
  logic [7:0]       tx_q, tx_d, tail_q, tail_d, dec, store_val;
  logic             esc_q, esc_d, tail_vld_q, tail_vld_d;
  logic             do_fetch, do_store, do_fault;

  assign rd_ptr   = (st_q == ST_CTRL) ? {1'b0, rx_byte_i[CTRL_AW-1:0]} : addr_q;
  assign rd_idx_o = rd_ptr[IW-1:0];
  assign wr_idx_o = addr_q[IW-1:0];
  assign dec      = rx_byte_i ^ ESC_FLIP;

  always_comb begin
    st_d       = st_q;
    addr_d     = addr_q;
    tx_d       = tx_q;
    esc_d      = esc_q;
    tail_d     = tail_q;
    tail_vld_d = tail_vld_q;
    we_o       = 1'b0;
    wdata_o    = rx_byte_i;
    flag_clr_o = 1'b0;
    do_fetch   = 1'b0;
    do_store   = 1'b0;
    do_fault   = 1'b0;
    store_val  = rx_byte_i;

    if (!cs_act_i) begin
      st_d       = ST_CTRL;
      tx_d       = FILL_BYTE;
      esc_d      = 1'b0;
      tail_vld_d = 1'b0;
    end else if (rx_valid_i) begin
      case (st_q)
        ST_CTRL: begin
          if (rx_byte_i == 8'h00 || rd_ptr >= NUM_L) begin
            do_fault = 1'b1;
          end else begin
            addr_d = rd_ptr;
            if (rx_byte_i[7]) begin
              st_d     = ST_READ;
              do_fetch = 1'b1;
            end else begin
              st_d = ST_WRITE;
              tx_d = FILL_BYTE;
            end
          end
        end
        ST_READ: begin
          if (rx_byte_i == 8'h00) begin
            st_d = ST_DONE;
            tx_d = FILL_BYTE;
          end else begin
            do_fetch = 1'b1;
          end
        end
        ST_WRITE: begin
          tx_d = FILL_BYTE;
          if (rx_byte_i == 8'h00) begin
            st_d = ST_DONE;
          end else if (esc_q) begin
            esc_d = 1'b0;
            if (needs_esc(dec)) begin
              do_store  = 1'b1;
              store_val = dec;
            end else begin
              do_fault = 1'b1;
            end
          end else if (rx_byte_i == ESC_CHAR) begin
            esc_d = 1'b1;
          end else begin
            do_store = 1'b1;
          end
        end
        ST_DONE:  tx_d = FILL_BYTE;
        default:  tx_d = FAULT_BYTE;
      endcase

      if (do_fetch) begin
        if (tail_vld_q) begin
          tx_d       = tail_q;
          tail_vld_d = 1'b0;
        end else if (rd_ptr >= NUM_L) begin
          do_fault = 1'b1;
        end else begin
          flag_clr_o = (rd_ptr == FLAG_L);
          addr_d     = (rd_ptr == BUF_L) ? rd_ptr : rd_ptr + 1'b1;
          if (needs_esc(rd_data_i)) begin
            tx_d       = ESC_CHAR;
            tail_d     = rd_data_i ^ ESC_FLIP;
            tail_vld_d = 1'b1;
          end else begin
            tx_d = rd_data_i;
          end
        end
      end

      if (do_store) begin
        if (addr_q >= NUM_L) begin
          do_fault = 1'b1;
        end else begin
          we_o    = 1'b1;
          wdata_o = store_val;
          addr_d  = (addr_q == BUF_L) ? addr_q : addr_q + 1'b1;
        end
      end

      if (do_fault) begin
        st_d = ST_FAULT;
        tx_d = FAULT_BYTE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_CTRL;
      addr_q     <= '0;
      tx_q       <= FILL_BYTE;
      esc_q      <= 1'b0;
      tail_q     <= '0;
      tail_vld_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      addr_q     <= addr_d;
      tx_q       <= tx_d;
      esc_q      <= esc_d;
      tail_q     <= tail_d;
      tail_vld_q <= tail_vld_d;
    end
  end

  assign tx_byte_o = tx_q;
  assign err_o     = (st_q == ST_FAULT);
  assign addr_o    = addr_q;
endmodule

// File: rtl/spi_rb_regs.sv
module spi_rb_regs #(
  parameter int unsigned NUM_REGS  = 32,
  parameter int unsigned FLAG_ADDR = 1,
  parameter int unsigned IW        = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [7:0]    wdata_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [7:0]    rd_data_o,
  input  logic [7:0]    evt_i,
  input  logic          flag_clr_i,
  output logic          irq_no
);
  logic [7:0] mem [NUM_REGS];
  logic [7:0] flag_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == FLAG_ADDR) begin : g_flag
      assign mem[g] = flag_q;
    end else begin : g_cell
      logic [7:0] cell_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                               cell_q <= '0;
        else if (we_i && wr_idx_i == IW'(g))       cell_q <= wdata_i;
      end
      assign mem[g] = cell_q;
    end
  end

  // new events win over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~{8{flag_clr_i}}) | evt_i;
  end

  assign rd_data_o = mem[rd_idx_i];
  assign irq_no    = ~|flag_q;
endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge #(
  parameter int unsigned NUM_REGS    = 32,
  parameter int unsigned BUF_ADDR    = 24,
  parameter int unsigned FLAG_ADDR   = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  output logic       miso_o,
  input  logic [7:0] evt_i,
  output logic       irq_no
);
  localparam int unsigned IW = $clog2(NUM_REGS);
  localparam int unsigned AW = spi_rb_pkg::CTRL_AW;

  logic          cs_act, rx_valid, we, flag_clr, err;
  logic [7:0]    rx_byte, tx_byte, rd_data, wdata;
  logic [IW-1:0] rd_idx, wr_idx;
  logic [AW:0]   addr;

  spi_rb_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .mosi_i,
    .tx_byte_i (tx_byte),
    .miso_o,
    .cs_act_o  (cs_act),
    .rx_byte_o (rx_byte),
    .rx_valid_o(rx_valid)
  );

  spi_rb_frame #(
    .NUM_REGS(NUM_REGS), .BUF_ADDR(BUF_ADDR), .FLAG_ADDR(FLAG_ADDR), .IW(IW)
  ) u_frame (
    .clk_i, .rst_ni,
    .cs_act_i  (cs_act),
    .rx_valid_i(rx_valid),
    .rx_byte_i (rx_byte),
    .rd_data_i (rd_data),
    .tx_byte_o (tx_byte),
    .rd_idx_o  (rd_idx),
    .wr_idx_o  (wr_idx),
    .we_o      (we),
    .wdata_o   (wdata),
    .flag_clr_o(flag_clr),
    .err_o     (err),
    .addr_o    (addr)
  );

  spi_rb_regs #(.NUM_REGS(NUM_REGS), .FLAG_ADDR(FLAG_ADDR), .IW(IW)) u_regs (
    .clk_i, .rst_ni,
    .we_i      (we),
    .wr_idx_i  (wr_idx),
    .wdata_i   (wdata),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .evt_i,
    .flag_clr_i(flag_clr),
    .irq_no
  );
endmodule

// File: rtl/spi_reg_bridge_chk.sv
module spi_reg_bridge_chk #(
  parameter int unsigned BUF_ADDR = 24,
  parameter int unsigned IW       = 5,
  parameter int unsigned AW       = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [7:0]    evt_i,
  input logic          irq_no,
  input logic          flag_clr,
  input logic          err,
  input logic          cs_act,
  input logic          we,
  input logic [IW-1:0] wr_idx,
  input logic [AW:0]   addr,
  input logic [7:0]    tx_byte
);
  a_r10_evt_pulls_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != 8'h00) |=> !irq_no);

  a_r10_release_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_no) |-> $past(flag_clr));

  a_r8_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err && cs_act) |=> err);

  a_r8_no_write_in_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err |-> !we);

  a_r9_buffer_holds_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && wr_idx == IW'(BUF_ADDR)) |=> $stable(addr));

  a_r6_no_raw_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err |-> (tx_byte != 8'h00));
endmodule

bind spi_reg_bridge spi_reg_bridge_chk #(.BUF_ADDR(BUF_ADDR), .IW(IW), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .evt_i   (evt_i),
  .irq_no  (irq_no),
  .flag_clr(flag_clr),
  .err     (err),
  .cs_act  (cs_act),
  .we      (we),
  .wr_idx  (wr_idx),
  .addr    (addr),
  .tx_byte (tx_byte)
);

// File: tb/spi_reg_bridge_tb.sv
`timescale 1ns/1ps
module spi_reg_bridge_tb;
  logic clk_i = 1'b0;
  logic rst_ni, sclk_i, cs_ni, mosi_i, miso_o, irq_no;
  logic [7:0] evt_i;

  int n_run  = 0;
  int n_fail = 0;
  logic [7:0] txb [16];
  logic [7:0] rxb [16];

  always #10 clk_i = ~clk_i;

  spi_reg_bridge u_dut (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .mosi_i, .miso_o, .evt_i, .irq_no
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi_i = tx[i];
      wait_clk(8);
      rx[i]  = miso_o;
      sclk_i = 1'b1;
      wait_clk(8);
      sclk_i = 1'b0;
    end
  endtask

  task automatic xfer(input int n);
    logic [7:0] r;
    cs_ni = 1'b0;
    wait_clk(10);
    for (int j = 0; j < n; j++) begin
      spi_byte(txb[j], r);
      rxb[j] = r;
    end
    wait_clk(10);
    cs_ni = 1'b1;
    wait_clk(20);
  endtask

  task automatic set5(input logic [7:0] a, b, c, d, e);
    txb[0] = a; txb[1] = b; txb[2] = c; txb[3] = d; txb[4] = e;
  endtask

  task automatic t_reset;
    chk("R1 irq_no after reset", {7'd0, irq_no}, 8'h01);
    chk("R1 idle miso", {7'd0, miso_o}, 8'h01);
    set5(8'h82, 8'hFF, 8'hFF, 8'hFF, 8'hFF); txb[5] = 8'h00;
    xfer(6);
    chk("R2 reply during control byte", rxb[0], 8'hFF);
    chk("R1/R6 reg2 zero escape lead", rxb[1], 8'h5C);
    chk("R1/R6 reg2 zero escape tail", rxb[2], 8'h20);
    chk("R1/R6 reg3 zero escape lead", rxb[3], 8'h5C);
    chk("R1/R6 reg3 zero escape tail", rxb[4], 8'h20);
  endtask

  task automatic t_plain_rw;
    set5(8'h02, 8'h11, 8'h22, 8'h33, 8'h00);
    xfer(5);
    for (int j = 0; j < 5; j++) chk("R4 write reply", rxb[j], 8'hFF);
    set5(8'h82, 8'hFF, 8'hFF, 8'hFF, 8'h00);
    xfer(5);
    chk("R3 read reg2", rxb[1], 8'h11);
    chk("R3 read reg3", rxb[2], 8'h22);
    chk("R3 read reg4", rxb[3], 8'h33);
  endtask

  task automatic t_escape;
    set5(8'h05, 8'hAA, 8'hAA, 8'hAA, 8'h00);
    xfer(5);
    set5(8'h05, 8'h5C, 8'h20, 8'h5C, 8'h7C); txb[5] = 8'h44; txb[6] = 8'h00;
    xfer(7);
    set5(8'h85, 8'hFF, 8'hFF, 8'hFF, 8'hFF); txb[5] = 8'hFF; txb[6] = 8'h00;
    xfer(7);
    chk("R7 decoded 00 resent lead", rxb[1], 8'h5C);
    chk("R6 zero tail", rxb[2], 8'h20);
    chk("R7 decoded 5C resent lead", rxb[3], 8'h5C);
    chk("R6 backslash tail", rxb[4], 8'h7C);
    chk("R3 read after escapes", rxb[5], 8'h44);
  endtask

  task automatic t_terminate;
    set5(8'h08, 8'h12, 8'h00, 8'h34, 8'h56);
    xfer(5);
    chk("R5 reply after terminator", rxb[3], 8'hFF);
    chk("R5 reply after terminator", rxb[4], 8'hFF);
    set5(8'h88, 8'hFF, 8'hFF, 8'hFF, 8'h00);
    xfer(5);
    chk("R5 reg8 written", rxb[1], 8'h12);
    chk("R5 reg9 untouched lead", rxb[2], 8'h5C);
    chk("R5 reg9 untouched tail", rxb[3], 8'h20);
  endtask

  task automatic t_bad_escape;
    set5(8'h0A, 8'h5C, 8'h41, 8'h77, 8'h00);
    xfer(5);
    chk("R8 fault reply", rxb[3], 8'h00);
    chk("R8 fault reply sticks", rxb[4], 8'h00);
    set5(8'h8A, 8'hFF, 8'hFF, 8'hFF, 8'hFF); txb[5] = 8'h00;
    xfer(6);
    chk("R7 reg10 not written", rxb[1], 8'h5C);
    chk("R7 reg10 not written", rxb[2], 8'h20);
    chk("R8 reg11 not written", rxb[3], 8'h5C);
    chk("R8 reg11 not written", rxb[4], 8'h20);
  endtask

  task automatic t_invalid;
    set5(8'h00, 8'h11, 8'h00, 8'h00, 8'h00);
    xfer(3);
    chk("R8 zero control reply", rxb[1], 8'h00);
    chk("R8 zero control sticky", rxb[2], 8'h00);
    set5(8'h3F, 8'h55, 8'h00, 8'h00, 8'h00);
    xfer(3);
    chk("R8 out of range address", rxb[1], 8'h00);
    set5(8'h1F, 8'h66, 8'h77, 8'h00, 8'h00);
    xfer(4);
    chk("R8 write past end", rxb[3], 8'h00);
    set5(8'h9F, 8'hFF, 8'hFF, 8'h00, 8'h00);
    xfer(4);
    chk("R8 last reg readable", rxb[1], 8'h66);
    chk("R8 read past end", rxb[2], 8'h00);
  endtask

  task automatic t_buffer;
    set5(8'h18, 8'h01, 8'h02, 8'h03, 8'h00);
    xfer(5);
    set5(8'h98, 8'hFF, 8'hFF, 8'hFF, 8'h00);
    xfer(5);
    for (int j = 1; j < 4; j++) chk("R9 buffer repeat read", rxb[j], 8'h03);
    set5(8'h99, 8'hFF, 8'hFF, 8'h00, 8'h00);
    xfer(4);
    chk("R9 next addr untouched", rxb[1], 8'h5C);
    chk("R9 next addr untouched", rxb[2], 8'h20);
  endtask

  task automatic t_irq;
    evt_i = 8'h05;
    wait_clk(1);
    evt_i = 8'h00;
    wait_clk(2);
    chk("R10 irq asserted", {7'd0, irq_no}, 8'h00);
    set5(8'h01, 8'hFF, 8'h00, 8'h00, 8'h00);
    xfer(3);
    chk("R10 write to flags ignored", {7'd0, irq_no}, 8'h00);
    set5(8'h81, 8'hFF, 8'hFF, 8'h00, 8'h00);
    xfer(4);
    chk("R10 flag cause", rxb[1], 8'h05);
    chk("R3 next after flags", rxb[2], 8'h11);
    chk("R10 irq released", {7'd0, irq_no}, 8'h01);
    xfer(4);
    chk("R10 flags cleared lead", rxb[1], 8'h5C);
    chk("R10 flags cleared tail", rxb[2], 8'h20);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    rst_ni = 1'b0; cs_ni = 1'b1; sclk_i = 1'b0; mosi_i = 1'b0; evt_i = 8'h00;
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(5);
    t_reset();
    t_plain_rw();
    t_escape();
    t_terminate();
    t_bad_escape();
    t_invalid();
    t_buffer();
    t_irq();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end
endmodule